// File: doc/BRIEF.md
# Display Controller Run Control and Event Status

This block holds the run control and the event status of a display controller. Software starts and stops scan-out through a run bit, chooses which events raise the interrupt line, and reads back sticky status bits. The pixel pipeline and the timing generator stay outside the block. They report frame end, FIFO underflow, loss of sync, vertical sync, line match, palette loaded and AC-bias count events as single-cycle input pulses.

A stop request does not cut the picture in the middle of a frame. After the run bit is cleared, the controller keeps scanning until the next frame end. It then goes idle and sets the done bit. A busy flag in the status word shows that a stop is still pending. The done interrupt has its own enable bit, separate from the event mask. Software can therefore mask every other event while stopping and still get the final done interrupt.

Registers are reached through a simple strobe interface with a write strobe, a read strobe, an address and write data. Read data is registered and appears in the cycle after the read strobe. It holds the register contents as they were before that clock edge.

Top module: `disp_run_ctrl`

## Requirements
- R1: After reset the control word, the status word (including busy), the read data and the interrupt output are all zero.
- R2: Control word (address 0): bit 0 is the run bit, bit 1 enables the done interrupt, bits 7:2 are mask bits for status bits 1 to 6 in order. Writing 1 to bit 0 while idle starts the controller. Busy (status bit 7) then reads 1.
- R3: Writing 0 to the run bit while running leaves busy at 1 until a frame-end pulse arrives. At that frame end the controller goes idle and sets done (status bit 0). Done is set at no other time.
- R4: Writing the run bit back to 1 while a stop is pending cancels the stop. A later frame end then leaves busy at 1 and done at 0.
- R5: Writes to the status word (address 1) never clear done. Done clears on the write that takes the run bit from 0 to 1.
- R6: Underflow (bit 1) and sync-lost (bit 2) set on their event pulses while busy. Status writes do not clear them. They clear on the write that takes the run bit from 1 to 0, and that clear wins over an event in the same cycle.
- R7: Vsync (bit 3), line (bit 4), palette loaded (bit 5) and AC-bias count (bit 6) set on their events while busy. They clear when a 1 is written to their bit of the status word. An event in the same cycle as the clear keeps the bit set.
- R8: Event pulses that arrive while the controller is idle set no status bit.
- R9: The interrupt output is registered. In the cycle after any status bit 1 to 6 is set together with its mask bit, or done is set together with the done enable, it is high. Otherwise it is low.
- R10: A read strobe returns the control word or the status word (with busy in bit 7) on the next cycle, as they were before the read edge. Other addresses read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (2) | Register address |
| wdata_i | input | DATA_W (8) | Write data |
| rdata_o | output | DATA_W (8) | Registered read data |
| frame_end_i | input | 1 | Last pixel of a frame has been sent |
| underflow_i | input | 1 | Pixel FIFO ran empty |
| sync_lost_i | input | 1 | Panel synchronisation lost |
| vsync_i | input | 1 | Vertical sync event |
| line_i | input | 1 | Programmed line reached |
| pal_loaded_i | input | 1 | Palette load finished |
| acb_i | input | 1 | AC-bias toggle count reached |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach is a stop that is still pending: the run bit has been cleared but no frame end has come yet. Re-enables, status writes and fault events can all land in that window. The directed part of the bench opens the window on purpose. It cancels a stop, lets a stop complete, and collides clears with events in the same cycle. The random part writes the run bit and pulses frame end often enough that the window opens and closes many times. Every read and every interrupt cycle is compared against a bench model.

// File: rtl/disp_run_pkg.sv
package disp_run_pkg;

    localparam int NUM_ST   = 7;
    localparam int NUM_MASK = NUM_ST - 1;
    localparam int REG_W    = NUM_ST + 1;

    localparam int ST_DONE  = 0;
    localparam int ST_UFLOW = 1;
    localparam int ST_SLOST = 2;
    localparam int ST_BUSY  = NUM_ST;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;

    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_DRAIN  = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        CLR_ON_ENABLE  = 2'd0,
        CLR_ON_DISABLE = 2'd1,
        CLR_ON_WRITE   = 2'd2
    } clr_kind_t;

    typedef struct packed {
        logic [NUM_MASK-1:0] mask;
        logic                done_ie;
        logic                en;
    } ctrl_t;

    function automatic clr_kind_t clr_kind(input int k);
        if (k == ST_DONE)
            return CLR_ON_ENABLE;
        else if (k == ST_UFLOW || k == ST_SLOST)
            return CLR_ON_DISABLE;
        else
            return CLR_ON_WRITE;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic [NUM_ST-1:0] st,
                                                     input logic busy);
        return {busy, st};
    endfunction

endpackage

// File: rtl/disp_run_fsm.sv
module disp_run_fsm
    import disp_run_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  wr_ctrl_i,
    input  ctrl_t wr_val_i,
    input  logic  frame_end_i,
    output ctrl_t ctrl_o,
    output logic  busy_o,
    output logic  en_rise_o,
    output logic  en_fall_o,
    output logic  drain_done_o
);
    ctrl_t      ctrl_q;
    run_state_t st_q;
    run_state_t st_d;

    assign en_rise_o    = wr_ctrl_i && wr_val_i.en && !ctrl_q.en;
    assign en_fall_o    = wr_ctrl_i && !wr_val_i.en && ctrl_q.en;
    assign drain_done_o = (st_q == RUN_DRAIN) && frame_end_i && !en_rise_o;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_IDLE:   if (en_rise_o) st_d = RUN_ACTIVE;
            RUN_ACTIVE: if (en_fall_o) st_d = RUN_DRAIN;
            RUN_DRAIN: begin
                if (en_rise_o)
                    st_d = RUN_ACTIVE;
                else if (frame_end_i)
                    st_d = RUN_IDLE;
            end
            default:    st_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
            st_q   <= RUN_IDLE;
        end else begin
            if (wr_ctrl_i)
                ctrl_q <= wr_val_i;
            st_q <= st_d;
        end
    end

    assign ctrl_o = ctrl_q;
    assign busy_o = (st_q != RUN_IDLE);

endmodule

// File: rtl/disp_status_bits.sv
module disp_status_bits
    import disp_run_pkg::*;
#(
    parameter int N = NUM_ST
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         active_i,
    input  logic         en_rise_i,
    input  logic         en_fall_i,
    input  logic         drain_done_i,
    input  logic [N-1:0] evt_i,
    input  logic         w1c_stb_i,
    input  logic [N-1:0] w1c_bits_i,
    output logic [N-1:0] st_o
);
    logic [N-1:0] st_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        if (clr_kind(k) == CLR_ON_ENABLE) begin : g_done
            logic unused_inputs;
            assign unused_inputs = evt_i[k] ^ w1c_bits_i[k];
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    st_q[k] <= 1'b0;
                else if (en_rise_i)
                    st_q[k] <= 1'b0;
                else if (drain_done_i)
                    st_q[k] <= 1'b1;
            end
        end else if (clr_kind(k) == CLR_ON_DISABLE) begin : g_fault
            logic unused_inputs;
            assign unused_inputs = w1c_bits_i[k];
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    st_q[k] <= 1'b0;
                else if (en_fall_i)
                    st_q[k] <= 1'b0;
                else if (active_i && evt_i[k])
                    st_q[k] <= 1'b1;
            end
        end else begin : g_w1c
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    st_q[k] <= 1'b0;
                else if (active_i && evt_i[k])
                    st_q[k] <= 1'b1;
                else if (w1c_stb_i && w1c_bits_i[k])
                    st_q[k] <= 1'b0;
            end
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/disp_irq_merge.sv
module disp_irq_merge
    import disp_run_pkg::*;
#(
    parameter int N = NUM_ST
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] st_i,
    input  logic [N-2:0] mask_i,
    input  logic         done_ie_i,
    output logic         irq_o
);
    logic [N-1:0] hit;
    logic         irq_q;

    assign hit[ST_DONE] = st_i[ST_DONE] & done_ie_i;
    for (genvar k = 1; k < N; k++) begin : g_hit
        assign hit[k] = st_i[k] & mask_i[k-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            irq_q <= 1'b0;
        else
            irq_q <= |hit;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/disp_run_ctrl.sv
module disp_run_ctrl
    import disp_run_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              frame_end_i,
    input  logic              underflow_i,
    input  logic              sync_lost_i,
    input  logic              vsync_i,
    input  logic              line_i,
    input  logic              pal_loaded_i,
    input  logic              acb_i,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    logic              wr_ctrl;
    logic              wr_stat;
    ctrl_t             wr_val;
    ctrl_t             ctrl_q;
    logic              busy;
    logic              en_rise;
    logic              en_fall;
    logic              drain_done;
    logic [NUM_ST-1:0] evt_vec;
    logic [NUM_ST-1:0] status_q;
    logic [DATA_W-1:0] rdata_q;

    assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
    assign wr_stat = wr_en_i && (addr_i == A_STAT);
    assign wr_val  = ctrl_t'(wdata_i[REG_W-1:0]);

    if (DATA_W > REG_W) begin : g_wide
        logic unused_upper;
        assign unused_upper = ^wdata_i[DATA_W-1:REG_W];
    end

    assign evt_vec = {acb_i, pal_loaded_i, line_i, vsync_i,
                      sync_lost_i, underflow_i, frame_end_i};

    disp_run_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_ctrl_i    (wr_ctrl),
        .wr_val_i     (wr_val),
        .frame_end_i  (frame_end_i),
        .ctrl_o       (ctrl_q),
        .busy_o       (busy),
        .en_rise_o    (en_rise),
        .en_fall_o    (en_fall),
        .drain_done_o (drain_done)
    );

    disp_status_bits #(.N(NUM_ST)) u_status (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .active_i     (busy),
        .en_rise_i    (en_rise),
        .en_fall_i    (en_fall),
        .drain_done_i (drain_done),
        .evt_i        (evt_vec),
        .w1c_stb_i    (wr_stat),
        .w1c_bits_i   (wdata_i[NUM_ST-1:0]),
        .st_o         (status_q)
    );

    disp_irq_merge #(.N(NUM_ST)) u_irq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .st_i      (status_q),
        .mask_i    (ctrl_q.mask),
        .done_ie_i (ctrl_q.done_ie),
        .irq_o     (irq_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            if (addr_i == A_CTRL)
                rdata_q <= DATA_W'(ctrl_q);
            else if (addr_i == A_STAT)
                rdata_q <= DATA_W'(pack_status(status_q, busy));
            else
                rdata_q <= '0;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/disp_run_ctrl_chk.sv
module disp_run_ctrl_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       wr_ctrl,
    input logic       new_en,
    input logic       frame_end_i,
    input logic       ctrl_en,
    input logic       busy,
    input logic [6:0] status_q,
    input logic       irq_o
);
    AST_DONE_NEEDS_FRAME_END: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(status_q[0]) |-> $past(frame_end_i) && $past(busy)) else $error("done without frame end"); // R3

    AST_BUSY_DROPS_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy) |-> $past(frame_end_i) && !$past(ctrl_en)) else $error("busy fell early"); // R3

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_q[0] && !(wr_ctrl && new_en)) |=> status_q[0]) else $error("done lost"); // R5

    AST_FAULTS_CLEAR_ON_DISABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_ctrl && !new_en && ctrl_en) |=> (status_q[2:1] == 2'b00)) else $error("fault kept"); // R6

    AST_IDLE_IGNORES_EVENTS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy && status_q[6:1] == 6'd0) |=> (status_q[6:1] == 6'd0)) else $error("idle event"); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_q == 7'd0) |=> !irq_o) else $error("spurious irq"); // R9

endmodule

bind disp_run_ctrl disp_run_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_ctrl     (wr_ctrl),
    .new_en      (wdata_i[0]),
    .frame_end_i (frame_end_i),
    .ctrl_en     (ctrl_q.en),
    .busy        (busy),
    .status_q    (status_q),
    .irq_o       (irq_o)
);

// File: tb/disp_run_ctrl_test.sv
`timescale 1ns/1ps
module disp_run_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [6:0] ev;
    logic       irq;

    always #2 clk = ~clk;

    disp_run_ctrl uut (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .frame_end_i(ev[0]), .underflow_i(ev[1]), .sync_lost_i(ev[2]),
        .vsync_i(ev[3]), .line_i(ev[4]), .pal_loaded_i(ev[5]), .acb_i(ev[6]),
        .irq_o(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // bench model: run state 0 idle, 1 running, 2 stop pending
    logic [7:0] m_ctrl;
    logic [6:0] m_st;
    int         m_run;
    logic       m_irq;
    logic [7:0] m_rdata;

    function automatic logic f_irq(input logic [6:0] st, input logic [7:0] c);
        return (|(st[6:1] & c[7:2])) | (st[0] & c[1]);
    endfunction

    function automatic logic [7:0] f_read(input logic [1:0] a, input logic [7:0] c,
                                          input logic [6:0] st, input int run);
        if (a == 2'd0) return c;
        if (a == 2'd1) return {run != 0, st};
        return 8'h00;
    endfunction

    function automatic logic [6:0] f_status(input logic [6:0] st, input int run,
                                            input logic rise, input logic fall,
                                            input logic ws, input logic [7:0] wd,
                                            input logic [6:0] e);
        logic [6:0] n;
        logic act;
        n = st;
        act = (run != 0);
        if (rise) n[0] = 1'b0;
        else if (run == 2 && e[0]) n[0] = 1'b1;
        for (int k = 1; k <= 2; k++) begin
            if (fall) n[k] = 1'b0;
            else if (act && e[k]) n[k] = 1'b1;
        end
        for (int k = 3; k <= 6; k++) begin
            if (act && e[k]) n[k] = 1'b1;
            else if (ws && wd[k]) n[k] = 1'b0;
        end
        return n;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit w, input bit [1:0] a, input bit [7:0] wd,
                        input bit r, input bit [6:0] e);
        logic rise, fall, wc, ws;
        wr_en = w; addr = a; wdata = wd; rd_en = r; ev = e;
        wc   = w && a == 2'd0;
        ws   = w && a == 2'd1;
        rise = wc && wd[0] && !m_ctrl[0];
        fall = wc && !wd[0] && m_ctrl[0];
        m_irq = f_irq(m_st, m_ctrl);
        if (r) m_rdata = f_read(a, m_ctrl, m_st, m_run);
        m_st = f_status(m_st, m_run, rise, fall, ws, wd, e);
        case (m_run)
            0: if (rise) m_run = 1;
            1: if (fall) m_run = 2;
            default: if (rise) m_run = 1; else if (e[0]) m_run = 0;
        endcase
        if (wc) m_ctrl = wd;
        @(negedge clk);
        wr_en = 0; rd_en = 0; ev = '0;
        chk("R9 interrupt vs model", {7'd0, irq}, {7'd0, m_irq});
        if (r) chk("R10 read data vs model", rdata, m_rdata);
    endtask

    task automatic rd_expect(input bit [1:0] a, input logic [7:0] exp, input string tag);
        step(0, a, 8'h00, 1, 7'h00);
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_C0DE));
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; ev = 0;
        m_ctrl = 0; m_st = 0; m_run = 0; m_irq = 0; m_rdata = 0;
        repeat (4) @(negedge clk);
        chk("R1 reset rdata", rdata, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst = 0;
        rd_expect(2'd0, 8'h00, "R1 reset control");
        rd_expect(2'd1, 8'h00, "R1 reset status");

        step(0, 0, 0, 0, 7'h7F);
        rd_expect(2'd1, 8'h00, "R8 idle events ignored");

        step(1, 2'd0, 8'hFF, 0, 0);
        rd_expect(2'd1, 8'h80, "R2 busy after enable");
        rd_expect(2'd0, 8'hFF, "R2 control readback");

        step(0, 0, 0, 0, 7'h08);
        step(0, 0, 0, 0, 7'h00);
        chk("R9 irq after masked vsync", {7'd0, irq}, 8'h01);

        step(1, 2'd1, 8'h08, 0, 7'h08);
        rd_expect(2'd1, 8'h88, "R7 set wins over clear");
        step(1, 2'd1, 8'h08, 0, 7'h00);
        rd_expect(2'd1, 8'h80, "R7 write one clears vsync");

        step(0, 0, 0, 0, 7'h06);
        step(1, 2'd1, 8'h7F, 0, 7'h00);
        rd_expect(2'd1, 8'h86, "R6 faults survive status write");

        step(1, 2'd2, 8'hFF, 0, 7'h00);
        rd_expect(2'd2, 8'h00, "R10 unused address reads zero");
        rd_expect(2'd0, 8'hFF, "R10 unused write ignored");

        step(1, 2'd0, 8'hFE, 0, 7'h02);
        rd_expect(2'd1, 8'h80, "R6 faults cleared by disable, R3 busy held");
        step(0, 0, 0, 0, 7'h00);
        rd_expect(2'd1, 8'h80, "R3 still pending without frame end");

        step(0, 0, 0, 0, 7'h01);
        rd_expect(2'd1, 8'h01, "R3 done at frame end");
        step(1, 2'd1, 8'h7F, 0, 7'h00);
        rd_expect(2'd1, 8'h01, "R5 done not write-clearable");
        chk("R9 done irq", {7'd0, irq}, 8'h01);

        step(1, 2'd0, 8'h02, 0, 7'h00);
        step(0, 0, 0, 0, 7'h00);
        chk("R9 done enable separate from mask", {7'd0, irq}, 8'h01);
        step(1, 2'd0, 8'h00, 0, 7'h00);
        step(0, 0, 0, 0, 7'h00);
        chk("R9 done enable off", {7'd0, irq}, 8'h00);

        step(1, 2'd0, 8'h01, 0, 7'h00);
        rd_expect(2'd1, 8'h80, "R5 done cleared by enable");

        step(1, 2'd0, 8'h00, 0, 7'h00);
        step(1, 2'd0, 8'h01, 0, 7'h00);
        step(0, 0, 0, 0, 7'h01);
        rd_expect(2'd1, 8'h80, "R4 cancelled stop keeps running");

        for (int i = 0; i < 4000; i++) begin
            bit        w, r;
            bit [1:0]  a;
            bit [7:0]  d;
            bit [6:0]  e;
            w = ($urandom % 4) == 0;
            a = 2'($urandom % 3);
            d = 8'($urandom);
            r = ($urandom % 2) == 0;
            e = 7'($urandom & $urandom & $urandom);
            step(w, a, d, r, e);
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule